// File: doc/BRIEF.md
# I2C Controller Byte Engine

This block is the bus-controller side of an I2C port. Software or a local sequencer programs it through a small byte-wide register port. It issues a START, and a write to the shift register then sends the first byte as the address byte. After that the engine moves one byte per transfer. At a programmable wait point it parks with SCL held low and raises a level interrupt. The wait point falls either after the 8th clock of a byte or after its 9th, acknowledge, clock. The engine stays parked until it gets a fresh shift-register write (when transmitting), a wait-release command (when receiving, or to run the acknowledge clock), a stop request or an exit command.

Bit timing comes from a fixed divider. One SCL period lasts `DIV` system clocks, split into four equal quarters. Within a byte, SDA is updated in the first quarter while SCL is low. SCL is released in the second quarter, the line is sampled in the third, and SCL is pulled low again in the fourth. Both bus inputs pass through a two-flop synchronizer. A START or STOP seen on the bus sets or clears the busy flag. If the engine releases SDA for a 1 but samples it low, it has lost arbitration and it lets go of both lines.

The state machine has these states:
- `S_IDLE`: both lines released.
- `S_START`: SDA falls while SCL is high, then SCL is pulled low.
- `S_READY`: holds SCL low until the address byte is written.
- `S_BITS`: eight bit slots.
- `S_ACK`: the ninth slot.
- `S_HOLD8`: the wait point after the 8th clock.
- `S_HOLD9`: the wait point after the 9th clock.
- `S_STOP`: SDA rises while SCL is high.

The transitions are:
- IDLE→START on an accepted start request.
- START→READY after four quarters.
- READY→BITS on a shift write.
- BITS→ACK or BITS→HOLD8 after the 8th bit, chosen by the wait-timing bit.
- HOLD8→ACK on wait release.
- ACK→BITS when a byte was received and ACKed in 8-clock mode; ACK→HOLD9 otherwise.
- HOLD9→BITS on a shift write (transmit) or on wait release (receive).
- HOLD8 or HOLD9→STOP on a stop request.
- STOP→IDLE after four quarters.
- Any state→IDLE on lost arbitration, on the exit command or on disable.

Top module: `i2c_byte_eng`

## Requirements
- R1: After reset every register reads 0, both line enables are low (lines released) and the interrupt is low.
- R2: Bit 0 of offset 0x00 switches the engine on (1) or off (0), and the next read shows the value written. While off, both lines are released and the engine is idle.
- R3: Writing control (0x08) with bit 1 set starts a START while the engine is idle and on: SDA is pulled low while SCL is high, then SCL is pulled low and held until the shift register (0x04) is written. The request has no effect when the bus is busy and flag bit 1 is 0.
- R4: The first shift write after a START is sent MSB first as the address byte, with the 7-bit address in bits 7:1 and bit 0 = 1 for a read. One SCL period is `DIV` clocks, and within a byte SDA never changes while SCL is high.
- R5: Control bit 3 = 1 places the wait point after the 9th clock, and 0 places it after the 8th. At a wait point SCL stays low and the interrupt stays high until the engine is released.
- R6: On transmitted bytes, status (0x18) bit 2 reads 1 when the target pulled SDA low on the 9th clock and 0 otherwise. At the 9th-clock wait, a shift write sends the next byte.
- R7: When receiving, reading the shift register returns the received byte (first bit in bit 7), and control bit 5 (wait release) continues. The engine drives ACK on the 9th clock when control bit 2 is 1 and NACK when it is 0. After a NACK it always waits after the 9th clock.
- R8: Control bit 0 at a wait point produces a STOP: SDA rises while SCL is high. A STOP seen on the bus sets status bit 0, and it raises the interrupt when control bit 4 is 1.
- R9: The interrupt is a level. Any read or write of offset 0x04 or 0x08 clears it, except in a cycle where a new event sets it.
- R10: Flag (0x20) bit 6 reads 1 from the moment the engine is switched on and after any START on the bus, and reads 0 after a STOP. Flag bit 1 set lets a start request through while the bus is busy.
- R11: If SDA is sampled low while the engine releases it for a 1, status bit 6 reads 1, both lines are released and the interrupt is raised.
- R12: Control bit 6 (exit) releases both lines at once and returns the engine to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the access |
| scl_in | input | 1 | SCL line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| irq | output | 1 | Level interrupt |

## Verification
The assertions rely on a few properties of the inputs:
- No target stretches SCL. The engine never reads SCL back, so it takes its own released SCL as high.
- `DIV` is at least 12, so the two-flop delay on SDA ends well before the sampling quarter.
- Each register access lasts one clock.
- Bit 6 of control is written only to abandon a transfer.

The bench's target model meets these conditions. It changes SDA only on SCL falling edges. It never holds SCL. It pulls SDA low only when acknowledging, returning data or, in the one arbitration case, while SCL is low before the address byte starts.

// File: rtl/i2c_byte_eng_pkg.sv
package i2c_byte_eng_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_READY, S_BITS, S_ACK, S_HOLD8, S_HOLD9, S_STOP
    } eng_state_t;

    localparam logic [5:0] OFS_EN    = 6'h00;
    localparam logic [5:0] OFS_SHIFT = 6'h04;
    localparam logic [5:0] OFS_CTRL  = 6'h08;
    localparam logic [5:0] OFS_STAT  = 6'h18;
    localparam logic [5:0] OFS_FLAG  = 6'h20;

    localparam int CB_EXIT = 6;
    localparam int CB_WREL = 5;
    localparam int CB_SPIE = 4;
    localparam int CB_WTIM = 3;
    localparam int CB_ACKE = 2;
    localparam int CB_STT  = 1;
    localparam int CB_SPT  = 0;

endpackage

// File: rtl/i2c_byte_eng_tick.sv
module i2c_byte_eng_tick #(
    parameter int QTR = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(QTR - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (!run || tick)  cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_byte_eng_sync.sv
module i2c_byte_eng_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_d, sda_d;
    logic       scl_s;

    assign scl_s = scl_ff[1];
    assign sda_s = sda_ff[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_in};
            sda_ff <= {sda_ff[0], sda_in};
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign start_det = scl_s && scl_d && sda_d && !sda_s;
    assign stop_det  = scl_s && scl_d && !sda_d && sda_s;
endmodule

// File: rtl/i2c_byte_eng.sv
module i2c_byte_eng
    import i2c_byte_eng_pkg::*;
#(
    parameter int DIV = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_sel,
    input  logic       reg_we,
    input  logic [5:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_in,
    output logic       scl_oe,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic       irq
);
    localparam int QTR = DIV / 4;

    eng_state_t st, st_n;
    logic [1:0] q, q_n;
    logic [2:0] bitcnt, bc_n;
    logic [7:0] sh, sh_n;
    logic       tx, tx_n, first, first_n, rw, rw_n, scl_n, sda_n;
    logic       en, spie, wtim, acke, allow, busy, ald, ackd, spd, irq_q;
    logic       tick, sda_s, start_det, stop_det;
    logic       lost, ack_upd, ack_val, ev_hold, start_go, ev;

    logic wr, wr_sh, wr_ctl, wr_en_on, acc_clr;
    logic cmd_stt, cmd_spt, cmd_wrel, cmd_exit;

    assign wr       = reg_sel && reg_we;
    assign wr_sh    = wr && (reg_addr == OFS_SHIFT);
    assign wr_ctl   = wr && (reg_addr == OFS_CTRL);
    assign wr_en_on = wr && (reg_addr == OFS_EN) && reg_wdata[0] && !en;
    assign acc_clr  = reg_sel && ((reg_addr == OFS_SHIFT) || (reg_addr == OFS_CTRL));
    assign cmd_stt  = wr_ctl && reg_wdata[CB_STT];
    assign cmd_spt  = wr_ctl && reg_wdata[CB_SPT];
    assign cmd_wrel = wr_ctl && reg_wdata[CB_WREL];
    assign cmd_exit = wr_ctl && reg_wdata[CB_EXIT];

    i2c_byte_eng_tick #(.QTR(QTR)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (en && !(st inside {S_IDLE, S_READY, S_HOLD8, S_HOLD9})),
        .tick (tick)
    );

    i2c_byte_eng_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_s    (sda_s),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    // next-state and line sequencing
    always_comb begin
        st_n = st; q_n = q; bc_n = bitcnt; sh_n = sh;
        tx_n = tx; first_n = first; rw_n = rw;
        scl_n = scl_oe; sda_n = sda_oe;
        lost = 1'b0; ack_upd = 1'b0; ack_val = 1'b0; ev_hold = 1'b0; start_go = 1'b0;
        unique case (st)
            S_IDLE: begin
                scl_n = 1'b0; sda_n = 1'b0;
                if (en && cmd_stt && (!busy || allow)) begin
                    st_n = S_START; q_n = 2'd0; start_go = 1'b1;
                end
            end
            S_START: if (tick) begin
                q_n = q + 2'd1;
                case (q)
                    2'd0:    sda_n = 1'b1;
                    2'd2:    scl_n = 1'b1;
                    2'd3:    st_n  = S_READY;
                    default: ;
                endcase
            end
            S_READY: if (wr_sh) begin
                st_n = S_BITS; q_n = 2'd0; bc_n = 3'd0; sh_n = reg_wdata;
                tx_n = 1'b1; first_n = 1'b1; rw_n = reg_wdata[0];
            end
            S_BITS: if (tick) begin
                q_n = q + 2'd1;
                case (q)
                    2'd0: sda_n = tx && !sh[7];
                    2'd1: scl_n = 1'b0;
                    2'd2: begin
                        if (tx && sh[7] && !sda_s) lost = 1'b1;
                        else sh_n = {sh[6:0], sda_s};
                    end
                    default: begin
                        scl_n = 1'b1;
                        bc_n  = bitcnt + 3'd1;
                        if (bitcnt == 3'd7) begin
                            st_n    = wtim ? S_ACK : S_HOLD8;
                            ev_hold = !wtim;
                        end
                    end
                endcase
            end
            S_ACK: if (tick) begin
                q_n = q + 2'd1;
                case (q)
                    2'd0: sda_n = !tx && acke;
                    2'd1: scl_n = 1'b0;
                    2'd2: if (tx) begin ack_upd = 1'b1; ack_val = !sda_s; end
                    default: begin
                        scl_n = 1'b1;
                        if (first) tx_n = !rw;
                        first_n = 1'b0;
                        if (!tx && sda_oe && !wtim) begin
                            st_n = S_BITS; bc_n = 3'd0;
                        end else begin
                            st_n = S_HOLD9; ev_hold = 1'b1;
                        end
                    end
                endcase
            end
            S_HOLD8: begin
                if (cmd_spt)       begin st_n = S_STOP; q_n = 2'd0; end
                else if (cmd_wrel) begin st_n = S_ACK;  q_n = 2'd0; end
            end
            S_HOLD9: begin
                if (cmd_spt) begin
                    st_n = S_STOP; q_n = 2'd0;
                end else if (tx && wr_sh) begin
                    st_n = S_BITS; q_n = 2'd0; bc_n = 3'd0; sh_n = reg_wdata;
                end else if (!tx && cmd_wrel) begin
                    st_n = S_BITS; q_n = 2'd0; bc_n = 3'd0;
                end
            end
            S_STOP: if (tick) begin
                q_n = q + 2'd1;
                case (q)
                    2'd0:    sda_n = 1'b1;
                    2'd1:    scl_n = 1'b0;
                    2'd2:    sda_n = 1'b0;
                    default: st_n  = S_IDLE;
                endcase
            end
        endcase
        if (lost || !en || (cmd_exit && st != S_IDLE)) begin
            st_n = S_IDLE; scl_n = 1'b0; sda_n = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_IDLE; q <= '0; bitcnt <= '0; sh <= '0;
            tx <= 1'b0; first <= 1'b0; rw <= 1'b0;
            scl_oe <= 1'b0; sda_oe <= 1'b0;
        end else begin
            st <= st_n; q <= q_n; bitcnt <= bc_n; sh <= sh_n;
            tx <= tx_n; first <= first_n; rw <= rw_n;
            scl_oe <= scl_n; sda_oe <= sda_n;
        end
    end

    assign ev = ev_hold || lost || (en && stop_det && spie);

    // settings, status and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en <= 1'b0; spie <= 1'b0; wtim <= 1'b0; acke <= 1'b0; allow <= 1'b0;
            busy <= 1'b0; ald <= 1'b0; ackd <= 1'b0; spd <= 1'b0; irq_q <= 1'b0;
        end else begin
            if (wr && reg_addr == OFS_EN)   en <= reg_wdata[0];
            if (wr_ctl) {spie, wtim, acke} <= {reg_wdata[CB_SPIE], reg_wdata[CB_WTIM], reg_wdata[CB_ACKE]};
            if (wr && reg_addr == OFS_FLAG) allow <= reg_wdata[1];
            if (wr_en_on)       busy <= 1'b1;
            else if (!en)       busy <= 1'b0;
            else if (start_det) busy <= 1'b1;
            else if (stop_det)  busy <= 1'b0;
            if (start_go) begin ald <= 1'b0; ackd <= 1'b0; spd <= 1'b0; end
            if (lost)     ald  <= 1'b1;
            if (ack_upd)  ackd <= ack_val;
            if (en && stop_det) spd <= 1'b1;
            if (ev)                     irq_q <= 1'b1;
            else if (acc_clr || !en)    irq_q <= 1'b0;
        end
    end

    assign irq = irq_q;

    always_comb begin
        case (reg_addr)
            OFS_EN:    reg_rdata = {7'd0, en};
            OFS_SHIFT: reg_rdata = sh;
            OFS_CTRL:  reg_rdata = {3'd0, spie, wtim, acke, 2'd0};
            OFS_STAT:  reg_rdata = {1'b0, ald, 3'd0, ackd, 1'b0, spd};
            OFS_FLAG:  reg_rdata = {1'b0, busy, 4'd0, allow, 1'b0};
            default:   reg_rdata = 8'd0;
        endcase
    end

    // R2: once off, both lines are released on the following cycle
    a_r2_off_release: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_oe && !sda_oe));
    // R4: inside a byte, SDA is steady while SCL is released
    a_r4_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_BITS && $past(st) == S_BITS && !$past(scl_oe) && !scl_oe)
        |-> (sda_oe == $past(sda_oe)));
    // R5: SCL held low at every parking state
    a_r5_hold_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st inside {S_READY, S_HOLD8, S_HOLD9}) |-> scl_oe);
    // R5: entering the 9th-clock wait raises the interrupt
    a_r5_irq_at_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HOLD9 && $past(st) != S_HOLD9) |-> irq_q);
    // R9: a register access clears the interrupt when nothing new sets it
    a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clr && !ev) |=> !irq_q);
    // R10: a STOP seen on the bus clears busy
    a_r10_busy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stop_det && !start_det) |=> !busy);
    // R11: lost arbitration lets go of both lines and interrupts
    a_r11_lost_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ald) |-> (!scl_oe && !sda_oe && irq_q));
endmodule

// File: tb/i2c_byte_eng_test.sv
`timescale 1ns/1ps
module i2c_byte_eng_test;
    localparam int DIV = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sel = 1'b0, we = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic scl_oe, sda_oe, irq;
    logic tgt_drv = 1'b0, force_low = 1'b0;
    wire  scl_w = !scl_oe;
    wire  sda_w = !(sda_oe || tgt_drv || force_low);

    int total = 0, bad = 0, cyc = 0;
    bit exp_idle = 1'b1;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    i2c_byte_eng #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .scl_in(scl_w), .scl_oe(scl_oe),
        .sda_in(sda_w), .sda_oe(sda_oe), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock model: while the bench expects an idle bus, no line may be pulled
    always @(negedge clk) if (rst_n && exp_idle) chk("R2 idle lines", {scl_oe, sda_oe}, 0);

    // target model at address 0x50
    logic [7:0] wq[$];
    logic [7:0] rq[$];
    logic [7:0] tb_b, tr;
    int   tcnt = 0, per_prev = 0, per_last = 0;
    bit   tact = 0, taddr = 0, tread = 0, tskip = 0, mack = 0, ps = 1, pd = 1;

    always @(scl_w or sda_w) begin
        if (scl_w && ps && pd && !sda_w) begin
            tact = 1; taddr = 1; tcnt = 0; tskip = 1; tgt_drv <= 1'b0;
        end else if (scl_w && ps && !pd && sda_w) begin
            tact = 0; tgt_drv <= 1'b0;
        end else if (scl_w && !ps) begin
            per_prev = per_last; per_last = cyc;
            if (tact) begin
                if (tcnt < 8) tb_b = {tb_b[6:0], sda_w};
                else mack = !sda_w;
            end
        end else if (!scl_w && ps && tact) begin
            if (tskip) tskip = 0;
            else begin
                tcnt++;
                if (tcnt == 8) begin
                    if (taddr) begin
                        if (tb_b[7:1] == 7'h50) begin tread = tb_b[0]; tgt_drv <= 1'b1; end
                        else begin tact = 0; tgt_drv <= 1'b0; end
                    end else if (!tread) begin
                        wq.push_back(tb_b); tgt_drv <= 1'b1;
                    end else tgt_drv <= 1'b0;
                end else if (tcnt == 9) begin
                    tcnt = 0;
                    if (tread && (taddr || mack)) begin
                        if (rq.size() > 0) tr = rq.pop_front(); else tr = 8'hFF;
                        tgt_drv <= !tr[7];
                    end else begin
                        tgt_drv <= 1'b0;
                        if (tread) tact = 0;
                    end
                    taddr = 0;
                end else if (tread && !taddr) tgt_drv <= !tr[7-tcnt];
            end
        end
        ps = scl_w; pd = sda_w;
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); sel = 0; we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk); sel = 1; we = 0; addr = a; #1 d = rdata;
        @(negedge clk); sel = 0;
    endtask

    task automatic wait_irq(string req);
        int n = 0;
        while (!irq && n < 3000) begin @(negedge clk); n++; end
        chk(req, irq, 1);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] d;
        rq.push_back(8'h96); rq.push_back(8'h5A);
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(6'h00, d); chk("R1 enable reg", d, 0);
        rd(6'h18, d); chk("R1 status reg", d, 0);
        rd(6'h20, d); chk("R1 flag reg", d, 0);
        chk("R1 irq", irq, 0);
        // R2 enable read-back, R10 busy after enable
        wr(6'h00, 8'h01);
        rd(6'h00, d); chk("R2 enable readback", d, 1);
        rd(6'h20, d); chk("R10 busy after enable", d, 8'h40);
        // R3 start refused while busy without allow
        wr(6'h08, 8'h0A); idle(60);
        chk("R3 refused start", {scl_oe, sda_oe}, 0);
        exp_idle = 0;
        wr(6'h20, 8'h02);
        // R3 accepted start, R4 address byte, R6 ack, R5 9th-clock wait
        wr(6'h08, 8'h0A); idle(40);
        chk("R3 start holds lines", {scl_oe, sda_oe}, 2'b11);
        wr(6'h04, 8'hA0); wait_irq("R5 irq after address");
        chk("R4 SCL period", per_last - per_prev, DIV);
        rd(6'h18, d); chk("R6 ack received", d, 8'h04);
        idle(40); chk("R5 held irq", irq, 1); chk("R5 held SCL", scl_oe, 1);
        wr(6'h04, 8'h3C); wait_irq("R6 data byte 1");
        wr(6'h04, 8'hC3); wait_irq("R6 data byte 2");
        // R8 stop with interrupt
        wr(6'h08, 8'h19); wait_irq("R8 stop irq");
        rd(6'h18, d); chk("R8 stop flag", d, 8'h05);
        rd(6'h20, d); chk("R10 busy cleared", d, 8'h02);
        chk("R6 bytes seen", wq.size(), 2);
        if (wq.size() == 2) begin
            chk("R6 first byte", wq[0], 8'h3C); chk("R6 second byte", wq[1], 8'hC3);
        end
        chk("R8 lines released", {scl_oe, sda_oe}, 0);
        // R7 read with 8th-clock waits
        wr(6'h08, 8'h0A); idle(40);
        wr(6'h04, 8'hA1); wait_irq("R7 addr irq");
        rd(6'h18, d); chk("R4 read address acked", d, 8'h04);
        wr(6'h08, 8'h24); wait_irq("R7 8th clock wait");
        rd(6'h04, d); chk("R7 first byte", d, 8'h96);
        wr(6'h08, 8'h24); wait_irq("R7 second wait");
        chk("R7 master ack", mack, 1);
        rd(6'h04, d); chk("R7 second byte", d, 8'h5A);
        wr(6'h08, 8'h20); wait_irq("R7 wait after nack");
        chk("R7 master nack", mack, 0);
        wr(6'h08, 8'h01); idle(80);
        rd(6'h20, d); chk("R8 bus free after stop", d, 8'h02);
        // R6 unknown address gets no ack
        wr(6'h08, 8'h0A); idle(40);
        wr(6'h04, 8'h22); wait_irq("R6 nack irq");
        rd(6'h18, d); chk("R6 no ack", d, 8'h00);
        wr(6'h08, 8'h09); idle(80);
        // R5 8th-clock wait on transmit
        wr(6'h08, 8'h02); idle(40);
        wr(6'h04, 8'hA0); wait_irq("R5 8th clock irq");
        rd(6'h18, d); chk("R5 no ack yet", d, 8'h00);
        wr(6'h08, 8'h20); wait_irq("R5 9th clock irq");
        rd(6'h18, d); chk("R5 ack after release", d, 8'h04);
        // R9 control read clears irq
        rd(6'h08, d); chk("R9 control readback", d, 8'h00);
        chk("R9 irq cleared", irq, 0);
        wr(6'h08, 8'h01); idle(80);
        // R11 arbitration loss
        wr(6'h08, 8'h0A); idle(40);
        force_low = 1;
        wr(6'h04, 8'hA0); wait_irq("R11 lost irq");
        chk("R11 lines released", {scl_oe, sda_oe}, 0);
        rd(6'h18, d); chk("R11 lost flag", d, 8'h40);
        force_low = 0; idle(20);
        // R12 exit
        wr(6'h08, 8'h0A); idle(40);
        wr(6'h04, 8'hA0); wait_irq("R12 hold before exit");
        wr(6'h08, 8'h48);
        chk("R12 exit releases", {scl_oe, sda_oe}, 0);
        idle(20);
        // R2 disable
        wr(6'h00, 8'h00);
        rd(6'h00, d); chk("R2 disable readback", d, 0);
        chk("R2 off lines", {scl_oe, sda_oe}, 0);
        exp_idle = 1; idle(20);
        finish_run();
    end
endmodule